// File: doc/BRIEF.md
# Two-Level Time-Window Partition Scheduler

This block hands a single execution resource to a set of partitions and, inside the partition that holds the resource, to that partition's tasks. A repeating frame of ticks is divided into configured time windows. Each window has a start tick, a length and an owning partition. The owner keeps the resource for the whole window and is never displaced before the window closes. Inside the window, the lowest-numbered ready task of the owner runs, which gives fixed priority. A more urgent task that becomes ready takes over on the next tick, and the displaced task continues once the more urgent one has used its budget.

Switch overhead is modelled as dead ticks, during which no task advances. Entering a window of a different partition costs `PART_CS` ticks. Changing the loaded task costs `TASK_CS` ticks. Each task has a period and a budget. At the last tick of every period the block compares the ticks the task received with its budget, raises a sticky miss flag on a shortfall, and then re-arms the task.

Window, task and frame tables are written through configuration ports. Writes are taken only while the block is in reset or disabled. The tables are not cleared by reset, so they can be loaded during reset. The scheduler state advances only on cycles where `en` and `tick` are both high. All outputs are registered and describe the tick that was just processed.

Top module: `part_sched`

## Requirements
- R1: With `en` and `tick` high, `frame_pos` advances by one per clock and returns to 0 after reaching `frame_len`-1 (a `frame_len` of 0 lets it wrap at 2^16). On any cycle with `en` or `tick` low, every output holds its value.
- R2: Tick t belongs to the valid, error-free window whose start s and length d satisfy s <= t < s+d. When windows overlap, the lowest window index wins. `part_valid` and `part_id` report that window's partition, and `part_id` reads 0 when no window covers t.
- R3: `win_err[i]` is high exactly when window i is valid and its length is not greater than `PART_CS`. Such a window is never granted.
- R4: Entering a window whose partition differs from the last granted partition makes the first `PART_CS` ticks of that window dead. During a dead tick `switch_busy` is 1 and `task_run` is 0. The loaded task is also forgotten.
- R5: Moving into another window of the same partition, directly or after a gap with no window, costs no partition-switch ticks.
- R6: Within the granted partition, the ready task with the lowest local index (0..3) is selected on every tick. A newly ready lower index preempts a running task.
- R7: When the selected task differs from the loaded one, `TASK_CS` dead ticks pass before it runs. If the selection changes during those ticks, the count restarts for the new task.
- R8: A task with period p>0 and budget e receives at most e run ticks per p-tick period. Periods count every processed tick, whether or not a window is open. At the period's last tick the executed count is cleared.
- R9: `deadline_miss[4*partition+task]` is set at the last tick of a period if the task's executed ticks in that period differ from its budget. Once set, it stays set until reset.
- R10: `idle` is 1 when no window is granted, or when the granted partition has no ready task. It is 0 whenever `task_run` is 1. `task_id` reads 0 when `task_run` is 0.
- R11: Configuration writes presented while `en` is high and reset is released are ignored.
- R12: A task configured with period 0 never runs and never sets its miss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of scheduler state |
| en | input | 1 | Scheduler enable; configuration is writable while low |
| tick | input | 1 | Advance one schedule tick |
| cfg_win_we | input | 1 | Window table write strobe |
| cfg_win_idx | input | 3 | Window entry index |
| cfg_win_valid | input | 1 | Window entry in use |
| cfg_win_start | input | 16 | Window first tick within the frame |
| cfg_win_dur | input | 16 | Window length in ticks |
| cfg_win_part | input | 2 | Partition owning the window |
| cfg_task_we | input | 1 | Task table write strobe |
| cfg_task_idx | input | 4 | Task entry, 4*partition+local index |
| cfg_task_period | input | 16 | Task period in ticks, 0 disables the task |
| cfg_task_budget | input | 16 | Run ticks owed per period |
| cfg_frame_we | input | 1 | Frame length write strobe |
| cfg_frame_len | input | 16 | Frame length in ticks |
| frame_pos | output | 16 | Position of the next tick within the frame |
| part_valid | output | 1 | A window was granted on the last tick |
| part_id | output | 2 | Partition granted on the last tick |
| task_run | output | 1 | A task executed on the last tick |
| task_id | output | 2 | Local index of the task that executed |
| switch_busy | output | 1 | Last tick was a partition- or task-switch dead tick |
| idle | output | 1 | No window, or no ready task in the granted partition |
| deadline_miss | output | 16 | Sticky per-task budget shortfall flags |
| win_err | output | 8 | Window too short to survive the partition switch |

## Verification
The collision of interest is a period boundary that lands on a tick where the same task runs or is being switched in. The last run tick must still be counted before the budget comparison, and the task must be ready again on the following tick. A second collision is a preemption that happens while task-switch dead ticks are still counting down, which must restart the count for the new task. The stimulus uses co-prime periods against a 20-tick frame, so that period ends drift across window edges, dead ticks and gaps, and it drops `tick` and `en` at irregular points. Every cycle is judged against a behavioural model that keeps counters per task and is written without reference to the RTL's structure.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
    localparam int SCH_TW   = 16;
    localparam int SCH_NP   = 4;
    localparam int SCH_NT   = 4;
    localparam int SCH_NW   = 8;
    localparam int SCH_PW   = $clog2(SCH_NP);
    localparam int SCH_KW   = $clog2(SCH_NT);
    localparam int SCH_WW   = $clog2(SCH_NW);
    localparam int SCH_NTOT = SCH_NP * SCH_NT;
    localparam int SCH_XW   = $clog2(SCH_NTOT);

    typedef logic [SCH_TW-1:0] tick_t;

    typedef struct packed {
        tick_t                      t;
        logic                       last_v;
        logic [SCH_PW-1:0]          last_part;
        logic                       prev_v;
        logic [SCH_WW-1:0]          prev_win;
        tick_t                      pcs;
        tick_t                      tcs;
        logic                       run_v;
        logic [SCH_KW-1:0]          run;
        logic [SCH_NTOT-1:0][SCH_TW-1:0] exe;
        logic [SCH_NTOT-1:0][SCH_TW-1:0] per;
        logic [SCH_NTOT-1:0]        miss;
        logic                       pv;
        logic [SCH_PW-1:0]          part;
        logic                       trun;
        logic [SCH_KW-1:0]          tsk;
        logic                       busy;
        logic                       idle;
    } sched_state_t;
endpackage

// File: rtl/sched_cfg.sv
`timescale 1ns/1ps
module sched_cfg
    import sched_pkg::*;
#(
    parameter int PART_CS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en,
    input  logic                             win_we,
    input  logic [SCH_WW-1:0]                win_idx,
    input  logic                             win_valid,
    input  tick_t                            win_start_i,
    input  tick_t                            win_dur_i,
    input  logic [SCH_PW-1:0]                win_part_i,
    input  logic                             task_we,
    input  logic [SCH_XW-1:0]                task_idx,
    input  tick_t                            task_period_i,
    input  tick_t                            task_budget_i,
    input  logic                             frame_we,
    input  tick_t                            frame_len_i,
    output logic [SCH_NW-1:0][SCH_TW-1:0]    win_start,
    output logic [SCH_NW-1:0][SCH_TW-1:0]    win_dur,
    output logic [SCH_NW-1:0][SCH_PW-1:0]    win_part,
    output logic [SCH_NW-1:0]                win_ok,
    output logic [SCH_NW-1:0]                win_err,
    output logic [SCH_NTOT-1:0][SCH_TW-1:0]  task_period,
    output logic [SCH_NTOT-1:0][SCH_TW-1:0]  task_budget,
    output tick_t                            frame_len
);
    localparam tick_t PCS_L = tick_t'(PART_CS);

    logic [SCH_NW-1:0] wv_q;
    logic              wr_open;

    assign wr_open = !en || !rst_n;

    always_ff @(posedge clk) begin
        if (wr_open && win_we) begin
            wv_q[win_idx]      <= win_valid;
            win_start[win_idx] <= win_start_i;
            win_dur[win_idx]   <= win_dur_i;
            win_part[win_idx]  <= win_part_i;
        end
        if (wr_open && task_we) begin
            task_period[task_idx] <= task_period_i;
            task_budget[task_idx] <= task_budget_i;
        end
        if (wr_open && frame_we) begin
            frame_len <= frame_len_i;
        end
    end

    for (genvar w = 0; w < SCH_NW; w++) begin : g_werr
        assign win_err[w] = wv_q[w] && (win_dur[w] <= PCS_L);
        assign win_ok[w]  = wv_q[w] && !win_err[w];
    end
endmodule

// File: rtl/sched_win_sel.sv
`timescale 1ns/1ps
module sched_win_sel
    import sched_pkg::*;
(
    input  tick_t                          now,
    input  logic [SCH_NW-1:0][SCH_TW-1:0]  start,
    input  logic [SCH_NW-1:0][SCH_TW-1:0]  dur,
    input  logic [SCH_NW-1:0]              ok,
    output logic                           hit,
    output logic [SCH_WW-1:0]              idx
);
    logic [SCH_NW-1:0] match;

    for (genvar w = 0; w < SCH_NW; w++) begin : g_match
        assign match[w] = ok[w] && (now >= start[w]) &&
                          ({1'b0, now} < ({1'b0, start[w]} + {1'b0, dur[w]}));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int w = SCH_NW - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1;
                idx = SCH_WW'(w);
            end
        end
    end
endmodule

// File: rtl/sched_task_pick.sv
`timescale 1ns/1ps
module sched_task_pick
    import sched_pkg::*;
(
    input  logic [SCH_NT-1:0]  rdy,
    output logic               sel_v,
    output logic [SCH_KW-1:0]  sel
);
    always_comb begin
        sel_v = 1'b0;
        sel   = '0;
        for (int k = SCH_NT - 1; k >= 0; k--) begin
            if (rdy[k]) begin
                sel_v = 1'b1;
                sel   = SCH_KW'(k);
            end
        end
    end
endmodule

// File: rtl/part_sched.sv
`timescale 1ns/1ps
module part_sched
    import sched_pkg::*;
#(
    parameter int PART_CS = 2,
    parameter int TASK_CS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 cfg_win_we,
    input  logic [SCH_WW-1:0]    cfg_win_idx,
    input  logic                 cfg_win_valid,
    input  logic [SCH_TW-1:0]    cfg_win_start,
    input  logic [SCH_TW-1:0]    cfg_win_dur,
    input  logic [SCH_PW-1:0]    cfg_win_part,
    input  logic                 cfg_task_we,
    input  logic [SCH_XW-1:0]    cfg_task_idx,
    input  logic [SCH_TW-1:0]    cfg_task_period,
    input  logic [SCH_TW-1:0]    cfg_task_budget,
    input  logic                 cfg_frame_we,
    input  logic [SCH_TW-1:0]    cfg_frame_len,
    output logic [SCH_TW-1:0]    frame_pos,
    output logic                 part_valid,
    output logic [SCH_PW-1:0]    part_id,
    output logic                 task_run,
    output logic [SCH_KW-1:0]    task_id,
    output logic                 switch_busy,
    output logic                 idle,
    output logic [SCH_NTOT-1:0]  deadline_miss,
    output logic [SCH_NW-1:0]    win_err
);
    localparam tick_t PCS_L = tick_t'(PART_CS);
    localparam tick_t TCS_L = tick_t'(TASK_CS);
    localparam tick_t ONE   = tick_t'(1);

    logic [SCH_NW-1:0][SCH_TW-1:0]   win_start, win_dur;
    logic [SCH_NW-1:0][SCH_PW-1:0]   win_part;
    logic [SCH_NW-1:0]               win_ok;
    logic [SCH_NTOT-1:0][SCH_TW-1:0] task_period, task_budget;
    tick_t                           frame_len;

    sched_state_t s_q, s_d;

    logic                  hit;
    logic [SCH_WW-1:0]     hidx;
    logic [SCH_PW-1:0]     hpart;
    logic [SCH_NP-1:0][SCH_NT-1:0] rdy;
    logic                  sel_v;
    logic [SCH_KW-1:0]     sel;
    logic                  sw;
    tick_t                 pcs_c, tcs_c;
    logic                  rv_c;
    logic [SCH_KW-1:0]     run_c;
    logic [SCH_XW-1:0]     xi;

    sched_cfg #(.PART_CS(PART_CS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en),
        .win_we(cfg_win_we), .win_idx(cfg_win_idx), .win_valid(cfg_win_valid),
        .win_start_i(cfg_win_start), .win_dur_i(cfg_win_dur), .win_part_i(cfg_win_part),
        .task_we(cfg_task_we), .task_idx(cfg_task_idx),
        .task_period_i(cfg_task_period), .task_budget_i(cfg_task_budget),
        .frame_we(cfg_frame_we), .frame_len_i(cfg_frame_len),
        .win_start(win_start), .win_dur(win_dur), .win_part(win_part),
        .win_ok(win_ok), .win_err(win_err),
        .task_period(task_period), .task_budget(task_budget), .frame_len(frame_len)
    );

    sched_win_sel u_wsel (
        .now(s_q.t), .start(win_start), .dur(win_dur), .ok(win_ok),
        .hit(hit), .idx(hidx)
    );

    assign hpart = win_part[hidx];

    for (genvar i = 0; i < SCH_NTOT; i++) begin : g_rdy
        assign rdy[i / SCH_NT][i % SCH_NT] =
            (task_period[i] != '0) && (s_q.exe[i] < task_budget[i]);
    end

    sched_task_pick u_pick (.rdy(rdy[hpart]), .sel_v(sel_v), .sel(sel));

    always_comb begin
        s_d   = s_q;
        sw    = 1'b0;
        pcs_c = s_q.pcs;
        tcs_c = s_q.tcs;
        rv_c  = s_q.run_v;
        run_c = s_q.run;
        xi    = '0;
        if (en && tick) begin
            s_d.pv   = hit;
            s_d.part = hit ? hpart : '0;
            s_d.trun = 1'b0;
            s_d.tsk  = '0;
            s_d.busy = 1'b0;
            s_d.idle = 1'b1;
            if (!hit) begin
                s_d.prev_v = 1'b0;
            end else begin
                sw = (!s_q.prev_v || s_q.prev_win != hidx) &&
                     (!s_q.last_v || s_q.last_part != hpart);
                if (sw) begin
                    pcs_c = PCS_L;
                    tcs_c = '0;
                    rv_c  = 1'b0;
                end
                s_d.last_v    = 1'b1;
                s_d.last_part = hpart;
                s_d.prev_v    = 1'b1;
                s_d.prev_win  = hidx;
                s_d.idle      = !sel_v;
                if (pcs_c != '0) begin
                    s_d.busy = 1'b1;
                    pcs_c    = pcs_c - ONE;
                end else if (sel_v) begin
                    if (!rv_c || run_c != sel) begin
                        rv_c  = 1'b1;
                        run_c = sel;
                        tcs_c = TCS_L;
                    end
                    if (tcs_c != '0) begin
                        s_d.busy = 1'b1;
                        tcs_c    = tcs_c - ONE;
                    end else begin
                        s_d.trun    = 1'b1;
                        s_d.tsk     = sel;
                        xi          = {hpart, sel};
                        s_d.exe[xi] = s_q.exe[xi] + ONE;
                    end
                end
                s_d.pcs   = pcs_c;
                s_d.tcs   = tcs_c;
                s_d.run_v = rv_c;
                s_d.run   = run_c;
            end
            for (int i = 0; i < SCH_NTOT; i++) begin
                if (task_period[i] != '0) begin
                    if (s_q.per[i] == task_period[i] - ONE) begin
                        if (s_d.exe[i] != task_budget[i]) s_d.miss[i] = 1'b1;
                        s_d.exe[i] = '0;
                        s_d.per[i] = '0;
                    end else begin
                        s_d.per[i] = s_q.per[i] + ONE;
                    end
                end
            end
            if (frame_len != '0 && s_q.t == frame_len - ONE) s_d.t = '0;
            else                                           s_d.t = s_q.t + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.idle <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_pos     = s_q.t;
    assign part_valid    = s_q.pv;
    assign part_id       = s_q.part;
    assign task_run      = s_q.trun;
    assign task_id       = s_q.tsk;
    assign switch_busy   = s_q.busy;
    assign idle          = s_q.idle;
    assign deadline_miss = s_q.miss;

    // R3
    bad_window_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !win_err[hidx]);

    // R10
    run_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_run |-> !idle);

    // R4
    dead_tick_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_busy |-> !task_run);

    for (genvar i = 0; i < SCH_NTOT; i++) begin : g_chk
        // R9
        miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(deadline_miss[i]) |-> deadline_miss[i]);
        // R8
        no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && tick && hit && hpart == SCH_PW'(i / SCH_NT) &&
             s_q.exe[i] >= task_budget[i])
            |=> !(task_run && task_id == SCH_KW'(i % SCH_NT)));
    end
endmodule

// File: tb/part_sched_tb.sv
`timescale 1ns/1ps
module part_sched_tb;
    localparam int PCS = 2;
    localparam int TCS = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, en = 1'b0, tick = 1'b0;
    logic        cfg_win_we = 1'b0, cfg_win_valid = 1'b0;
    logic [2:0]  cfg_win_idx = '0;
    logic [15:0] cfg_win_start = '0, cfg_win_dur = '0;
    logic [1:0]  cfg_win_part = '0;
    logic        cfg_task_we = 1'b0;
    logic [3:0]  cfg_task_idx = '0;
    logic [15:0] cfg_task_period = '0, cfg_task_budget = '0;
    logic        cfg_frame_we = 1'b0;
    logic [15:0] cfg_frame_len = '0;
    logic [15:0] frame_pos;
    logic        part_valid, task_run, switch_busy, idle;
    logic [1:0]  part_id, task_id;
    logic [15:0] deadline_miss;
    logic [7:0]  win_err;

    always #10 clk = ~clk;

    part_sched #(.PART_CS(PCS), .TASK_CS(TCS)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .cfg_win_we(cfg_win_we), .cfg_win_idx(cfg_win_idx), .cfg_win_valid(cfg_win_valid),
        .cfg_win_start(cfg_win_start), .cfg_win_dur(cfg_win_dur), .cfg_win_part(cfg_win_part),
        .cfg_task_we(cfg_task_we), .cfg_task_idx(cfg_task_idx),
        .cfg_task_period(cfg_task_period), .cfg_task_budget(cfg_task_budget),
        .cfg_frame_we(cfg_frame_we), .cfg_frame_len(cfg_frame_len),
        .frame_pos(frame_pos), .part_valid(part_valid), .part_id(part_id),
        .task_run(task_run), .task_id(task_id), .switch_busy(switch_busy),
        .idle(idle), .deadline_miss(deadline_miss), .win_err(win_err)
    );

    int n_chk = 0, n_fail = 0;

    // behavioural reference: configuration
    int m_wv[8], m_ws[8], m_wd[8], m_wp[8];
    int m_pl[16], m_bud[16];
    int m_fl = 0;
    // behavioural reference: state and expected outputs
    int m_t, m_last, m_prev, m_pcs, m_tcs, m_run;
    int m_exe[16], m_per[16];
    bit m_miss[16];
    int o_pv, o_part, o_run, o_task, o_busy, o_idle;

    always @(posedge clk) begin
        if (!en || !rst_n) begin
            if (cfg_win_we) begin
                m_wv[cfg_win_idx] = cfg_win_valid; m_ws[cfg_win_idx] = cfg_win_start;
                m_wd[cfg_win_idx] = cfg_win_dur;   m_wp[cfg_win_idx] = cfg_win_part;
            end
            if (cfg_task_we) begin
                m_pl[cfg_task_idx] = cfg_task_period; m_bud[cfg_task_idx] = cfg_task_budget;
            end
            if (cfg_frame_we) m_fl = cfg_frame_len;
        end
    end

    function automatic bit m_ready(int i);
        return m_pl[i] != 0 && m_exe[i] < m_bud[i];
    endfunction

    task automatic model_tick();
        int hit = -1;
        for (int w = 0; w < 8; w++)
            if (hit < 0 && m_wv[w] != 0 && m_wd[w] > PCS &&
                m_t >= m_ws[w] && m_t < m_ws[w] + m_wd[w]) hit = w;
        o_pv = 0; o_part = 0; o_run = 0; o_task = 0; o_busy = 0; o_idle = 1;
        if (hit < 0) m_prev = -1;
        else begin
            int p = m_wp[hit];
            int s = -1;
            o_pv = 1; o_part = p;
            if (hit != m_prev && p != m_last) begin m_pcs = PCS; m_run = -1; m_tcs = 0; end
            m_last = p; m_prev = hit;
            for (int k = 3; k >= 0; k--) if (m_ready(p*4 + k)) s = k;
            o_idle = (s < 0);
            if (m_pcs > 0) begin o_busy = 1; m_pcs--; end
            else if (s >= 0) begin
                if (s != m_run) begin m_run = s; m_tcs = TCS; end
                if (m_tcs > 0) begin o_busy = 1; m_tcs--; end
                else begin o_run = 1; o_task = s; m_exe[p*4 + s]++; end
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (m_pl[i] != 0) begin
                if (m_per[i] == m_pl[i] - 1) begin
                    if (m_exe[i] != m_bud[i]) m_miss[i] = 1;
                    m_exe[i] = 0; m_per[i] = 0;
                end else m_per[i]++;
            end
        end
        if (m_fl != 0 && m_t == m_fl - 1) m_t = 0; else m_t = (m_t + 1) % 65536;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t = 0; m_last = -1; m_prev = -1; m_pcs = 0; m_tcs = 0; m_run = -1;
            for (int i = 0; i < 16; i++) begin m_exe[i] = 0; m_per[i] = 0; m_miss[i] = 0; end
            o_pv = 0; o_part = 0; o_run = 0; o_task = 0; o_busy = 0; o_idle = 1;
        end else if (en && tick) model_tick();
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int m_miss_vec();
        int v = 0;
        for (int i = 0; i < 16; i++) if (m_miss[i]) v |= (1 << i);
        return v;
    endfunction

    function automatic int m_err_vec();
        int v = 0;
        for (int w = 0; w < 8; w++) if (m_wv[w] != 0 && m_wd[w] <= PCS) v |= (1 << w);
        return v;
    endfunction

    task automatic compare_all();
        chk("R1 frame_pos", frame_pos, m_t);
        chk("R2 part_valid", part_valid, o_pv);
        chk("R2 part_id", part_id, o_part);
        chk("R6 R8 R12 task_run", task_run, o_run);
        chk("R6 R10 task_id", task_id, o_task);
        chk("R4 R5 R7 switch_busy", switch_busy, o_busy);
        chk("R10 idle", idle, o_idle);
        chk("R9 R12 deadline_miss", deadline_miss, m_miss_vec());
        chk("R3 win_err", win_err, m_err_vec());
    endtask

    task automatic wr_win(int i, int v, int s, int d, int p);
        @(negedge clk);
        cfg_win_we = 1; cfg_win_idx = 3'(i); cfg_win_valid = v[0];
        cfg_win_start = 16'(s); cfg_win_dur = 16'(d); cfg_win_part = 2'(p);
        @(negedge clk); cfg_win_we = 0;
    endtask

    task automatic wr_task(int i, int per, int bud);
        @(negedge clk);
        cfg_task_we = 1; cfg_task_idx = 4'(i);
        cfg_task_period = 16'(per); cfg_task_budget = 16'(bud);
        @(negedge clk); cfg_task_we = 0;
    endtask

    int run0_first = 0;
    int run_disabled = 0;
    bit first_period = 1;

    task automatic run_cycles(int n, int gap_mod);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare_all();
            if (task_run && part_id == 0 && task_id == 0 && first_period) run0_first++;
            if (task_run && part_id == 0 && task_id == 2) run_disabled++;
            if (frame_pos >= 10) first_period = 0;
            tick = (gap_mod == 0) ? 1'b1 : ((c % gap_mod) != gap_mod - 1);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int w = 0; w < 8; w++) wr_win(w, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) wr_task(i, 0, 0);
        wr_win(0, 1, 0, 6, 0);
        wr_win(1, 1, 6, 5, 1);
        wr_win(2, 1, 11, 4, 1);
        wr_win(3, 1, 15, 2, 2);
        wr_win(4, 1, 3, 4, 3);
        wr_win(5, 1, 17, 3, 2);
        wr_task(0, 10, 2);  wr_task(1, 20, 3);  wr_task(2, 0, 5);  wr_task(3, 40, 1);
        wr_task(4, 5, 1);   wr_task(5, 20, 5);  wr_task(7, 20, 9);
        wr_task(8, 7, 1);   wr_task(9, 13, 2);
        @(negedge clk);
        cfg_frame_we = 1; cfg_frame_len = 16'd20;
        @(negedge clk); cfg_frame_we = 0;
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset frame_pos", frame_pos, 0);
        chk("R10 reset idle", idle, 1);
        chk("R2 reset part_valid", part_valid, 0);
        chk("R9 reset deadline_miss", deadline_miss, 0);
        chk("R3 window 3 flagged", win_err, 8'b0000_1000);
        en = 1; tick = 1;
        run_cycles(150, 0);
        chk("R8 task 0 ticks in first period", run0_first, 2);
        en = 0;
        run_cycles(5, 0);
        en = 1;
        run_cycles(100, 7);
        // R11: write while enabled must be ignored
        @(negedge clk);
        compare_all();
        cfg_win_we = 1; cfg_win_idx = 3'd0; cfg_win_valid = 1'b1;
        cfg_win_start = 16'd0; cfg_win_dur = 16'd6; cfg_win_part = 2'd1;
        @(negedge clk);
        compare_all();
        cfg_win_we = 0;
        for (int c = 0; c < 60 && frame_pos != 16'd3; c++) begin
            @(negedge clk); compare_all();
        end
        chk("R11 window 0 keeps partition 0", part_id, 0);
        run_cycles(200, 5);
        rst_n = 0;
        @(negedge clk);
        chk("R9 miss cleared by reset", deadline_miss, 0);
        rst_n = 1;
        run_cycles(120, 0);
        chk("R12 disabled task never ran", run_disabled, 0);
        chk("R12 disabled task never flagged", deadline_miss[2], 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule